// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

This block sits between a 32-bit big-endian host port and a register file whose registers each have a native width of one, two or four bytes. The host asks for a byte, a halfword or a word. The adapter turns each request into one or more accesses at the native width on a downstream register port. A parameter table gives the native width of every aligned 4-byte group of offsets, and that table drives the conversion.

There are three kinds of conversion. When the host size matches the native width, the adapter makes a single pass-through access. When the host is narrower than the register, the adapter reads the whole register: for a read it extracts the addressed lanes, and for a write it merges the new lanes and writes the register back. When the host is wider than the register, the adapter splits the request into consecutive native-width pieces. The first piece is the most significant.

A small sequencer runs each request. It issues at most one downstream access per cycle. It keeps the host stalled until the last downstream access finishes, and then it returns a single acknowledge.

Top module: `mwb_adapter`

## Requirements
- R1: After reset, hostReady is 1 and both hostAck and regReq are 0.
- R2: Only the low 10 bits of hostAddr form the offset. An offset of 0x200 or above makes no downstream access and is acknowledged one cycle after acceptance. A rejected read returns 0.
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word; code 3 counts as word on both hostSize and regWidth. A group's width code sits at WIDTH_MAP bits [2g+1:2g], where g is offset bits [8:2]. By default, groups 0-15 hold byte registers, groups 16-31 hold halfword registers, groups 32-47 hold word registers, and all other groups hold byte registers. When the host size equals the native width, the adapter makes exactly one access of that width. Every downstream address is aligned to regWidth.
- R4: A byte read from a wider register makes one read of the whole register at its aligned address. It returns the addressed byte, and the lowest offset is the most significant byte.
- R5: A write narrower than the register makes one full-width read and then one full-width write at the same address. Only the addressed bytes change.
- R6: A halfword access to a word register uses offset bit 1 to pick the half: 0 selects bits 31:16 and 1 selects bits 15:0.
- R7: A host access wider than the register becomes host-size / native-width accesses at ascending addresses. The first access carries the most significant part. Read pieces are concatenated in that order, right-aligned in hostRdata.
- R8: A request is accepted when hostReq and hostReady are both 1. hostReady then stays 0 until the response. hostAck is a one-cycle pulse, asserted one cycle after the final downstream access completes.
- R9: regReq is held with stable regAddr, regWidth, regWe and regWdata until regAck. At most one downstream access completes per cycle.
- R10: Offset bits below the host access size are ignored; the access is aligned down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host request valid |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostSize | input | 2 | Host access size code |
| hostAddr | input | HOST_AW | Host byte address |
| hostWdata | input | 32 | Host write data, right-aligned |
| hostReady | output | 1 | Adapter idle and able to accept |
| hostAck | output | 1 | One-cycle response pulse |
| hostRdata | output | 32 | Read data, right-aligned, valid with hostAck on reads |
| regReq | output | 1 | Downstream access request |
| regWe | output | 1 | Downstream write (1) or read (0) |
| regWidth | output | 2 | Downstream access width code |
| regAddr | output | 10 | Downstream register offset |
| regWdata | output | 32 | Downstream write data, right-aligned |
| regRdata | input | 32 | Downstream read data, right-aligned |
| regAck | input | 1 | Downstream access completes this cycle |

## Verification
The embedded assertions cover the following on every cycle:
- the acknowledge is a single-cycle pulse;
- the port stalls after a request is accepted;
- a rejected offset goes straight to a response with no downstream request;
- downstream requests hold steady while regAck is low;
- every downstream address is aligned to its width and stays inside the mapped range.

The following can only be shown by the bench's directed scenarios against a byte-array register model:
- big-endian lane selection;
- merging during read-modify-write;
- the order and number of split pieces;
- ignored low offset bits;
- address masking;
- the exact response latency.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  localparam int DATA_W    = 32;
  localparam int OFF_W     = 10;
  localparam int OFF_LIMIT = 512;
  localparam int NGROUPS   = OFF_LIMIT / 4;
  localparam int GIDX_W    = $clog2(NGROUPS);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RESP   = 2'd2
  } seqState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture a new host request
    logic step;   // current downstream access completes
    logic busy;   // a downstream access is being presented
  } dpCtl_t;

  // Default native-width map: byte, halfword and word register banks.
  function automatic logic [2*NGROUPS-1:0] defaultWidthMap();
    logic [2*NGROUPS-1:0] m;
    m = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (g >= 16 && g < 32)      m[2*g +: 2] = 2'd1;
      else if (g >= 32 && g < 48) m[2*g +: 2] = 2'd2;
    end
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] code);
    case (code)
      2'd0:    laneMask = 32'h0000_00FF;
      2'd1:    laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/mwb_control.sv
module mwb_control
  import mwb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   hostReq,
  input  logic   regAck,
  input  logic   isLast,
  input  logic   isReject,
  output logic   hostReady,
  output logic   hostAck,
  output logic   regReq,
  output dpCtl_t ctl
);
  seqState_e state, stateNext;
  logic accept;

  assign accept    = hostReq && (state == ST_IDLE);
  assign hostReady = (state == ST_IDLE);
  assign hostAck   = (state == ST_RESP);
  assign regReq    = (state == ST_ACCESS);

  assign ctl.load = accept;
  assign ctl.step = (state == ST_ACCESS) && regAck;
  assign ctl.busy = (state == ST_ACCESS);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept) stateNext = isReject ? ST_RESP : ST_ACCESS;
      ST_ACCESS: if (regAck && isLast) stateNext = ST_RESP;
      ST_RESP:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: response is a single-cycle pulse
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);
  // R8: host port stalls once a request is taken
  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady) |=> !hostReady);
  // R2: rejected offsets respond at once without a downstream access
  p_reject_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady && isReject) |=> (hostAck && !regReq));
  // R9: request held until acknowledged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> regReq);
endmodule

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter logic [2*NGROUPS-1:0] WIDTH_MAP = defaultWidthMap()
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               hostWe,
  input  logic [1:0]         hostSize,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  regRdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic [OFF_W-1:0]   regAddr,
  output logic [1:0]         regWidth,
  output logic               regWe,
  output logic [DATA_W-1:0]  regWdata,
  output logic               isLast,
  output logic               isReject
);
  logic [OFF_W-1:0]  hostOff;
  logic [1:0]        mapCode, normWc, normSz;
  logic              unusedAddrBits;

  logic [OFF_W-1:0]  offQ;
  logic [1:0]        szQ, wcQ, pieceQ;
  logic              weQ, rmwQ;
  logic [DATA_W-1:0] wdQ, acc;

  logic              split;
  logic [OFF_W-1:0]  szMask, natMask, baseOff, unitOff, pieceOff;
  logic [1:0]        lastPiece, laneIdx;
  logic [5:0]        laneShift, pieceShift;
  logic [DATA_W-1:0] hostMask, natDataMask, mergeMask;

  // Request decode
  assign hostOff        = hostAddr[OFF_W-1:0];
  assign unusedAddrBits = ^hostAddr[HOST_AW-1:OFF_W];
  assign isReject       = hostOff >= OFF_W'(OFF_LIMIT);
  assign mapCode        = WIDTH_MAP[2*int'(hostOff[GIDX_W+1:2]) +: 2];
  assign normWc         = (mapCode == 2'd3) ? 2'd2 : mapCode;
  assign normSz         = (hostSize == 2'd3) ? 2'd2 : hostSize;

  // Piece and lane arithmetic
  always_comb begin
    split       = wcQ < szQ;
    szMask      = OFF_W'((1 << szQ) - 1);
    natMask     = OFF_W'((1 << wcQ) - 1);
    baseOff     = offQ & ~szMask;
    unitOff     = offQ & ~natMask;
    pieceOff    = OFF_W'(pieceQ) << wcQ;
    lastPiece   = 2'((1 << (int'(szQ) - int'(wcQ))) - 1);
    laneIdx     = offQ[1:0] & natMask[1:0] & ~szMask[1:0];
    laneShift   = 6'(8 * ((1 << wcQ) - (1 << szQ) - int'(laneIdx)));
    pieceShift  = 6'((8 << szQ) - ((int'(pieceQ) + 1) << (int'(wcQ) + 3)));
    hostMask    = laneMask(szQ);
    natDataMask = laneMask(wcQ);
    mergeMask   = hostMask << laneShift;
  end

  // Downstream access
  always_comb begin
    regWidth = wcQ;
    regAddr  = split ? (baseOff + pieceOff) : unitOff;
    regWe    = weQ && (split || (wcQ == szQ) || rmwQ);
    if (split)
      regWdata = (wdQ >> pieceShift) & natDataMask;
    else if (wcQ == szQ)
      regWdata = wdQ & hostMask;
    else
      regWdata = (acc & ~mergeMask) | ((wdQ & hostMask) << laneShift);
    if (split)
      isLast = (pieceQ == lastPiece);
    else
      isLast = !(weQ && (wcQ != szQ) && !rmwQ);
  end

  assign hostRdata = acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ <= '0; szQ <= '0; wcQ <= '0; weQ <= 1'b0; wdQ <= '0;
      acc <= '0; pieceQ <= '0; rmwQ <= 1'b0;
    end else if (ctl.load) begin
      offQ   <= hostOff;
      szQ    <= normSz;
      wcQ    <= normWc;
      weQ    <= hostWe;
      wdQ    <= hostWdata;
      acc    <= '0;
      pieceQ <= '0;
      rmwQ   <= 1'b0;
    end else if (ctl.step) begin
      if (split) begin
        acc    <= (acc << (8 << wcQ)) | (regRdata & natDataMask);
        pieceQ <= pieceQ + 2'd1;
      end else if (weQ) begin
        if (wcQ != szQ && !rmwQ) acc <= regRdata & natDataMask;
        rmwQ <= 1'b1;
      end else begin
        acc <= (regRdata >> laneShift) & hostMask;
      end
    end
  end

  // R2: downstream offsets stay inside the mapped range
  p_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> (regAddr < OFF_W'(OFF_LIMIT)));
  // R3: downstream address aligned to its width
  p_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> ((regAddr & natMask) == '0));
  // R9: presented access does not change while waiting
  p_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.step) |=> ($stable(regAddr) && $stable(regWdata)
                                 && $stable(regWidth) && $stable(regWe)));
endmodule

// File: rtl/mwb_adapter.sv
module mwb_adapter
  import mwb_pkg::*;
#(
  parameter int HOST_AW = 16,
  parameter logic [2*NGROUPS-1:0] WIDTH_MAP = defaultWidthMap()
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReq,
  input  logic               hostWe,
  input  logic [1:0]         hostSize,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostReady,
  output logic               hostAck,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               regReq,
  output logic               regWe,
  output logic [1:0]         regWidth,
  output logic [OFF_W-1:0]   regAddr,
  output logic [DATA_W-1:0]  regWdata,
  input  logic [DATA_W-1:0]  regRdata,
  input  logic               regAck
);
  dpCtl_t ctl;
  logic   isLast, isReject;

  mwb_control uCtl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .regAck(regAck),
    .isLast(isLast), .isReject(isReject), .hostReady(hostReady),
    .hostAck(hostAck), .regReq(regReq), .ctl(ctl)
  );

  mwb_datapath #(.HOST_AW(HOST_AW), .WIDTH_MAP(WIDTH_MAP)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostWe(hostWe), .hostSize(hostSize),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .regRdata(regRdata),
    .hostRdata(hostRdata), .regAddr(regAddr), .regWidth(regWidth),
    .regWe(regWe), .regWdata(regWdata), .isLast(isLast), .isReject(isReject)
  );
endmodule

// File: tb/mwb_adapter_test.sv
module mwb_adapter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [15:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostAck, regReq, regWe, regAck;
  logic [31:0] hostRdata, regWdata, regRdata;
  logic [1:0]  regWidth;
  logic [9:0]  regAddr;
  logic        ackOn = 1'b1;
  logic [7:0]  mem [0:511];
  int          accCnt = 0;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  mwb_adapter #(.HOST_AW(16)) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostAck(hostAck), .hostRdata(hostRdata),
    .regReq(regReq), .regWe(regWe), .regWidth(regWidth), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck)
  );

  // Byte-array register model, big-endian within each register
  assign regAck = regReq && ackOn;
  always_comb begin
    case (regWidth)
      2'd0:    regRdata = {24'h0, mem[regAddr]};
      2'd1:    regRdata = {16'h0, mem[regAddr], mem[regAddr+10'd1]};
      default: regRdata = {mem[regAddr], mem[regAddr+10'd1],
                           mem[regAddr+10'd2], mem[regAddr+10'd3]};
    endcase
  end
  always @(posedge clk) begin
    if (regReq && regAck) begin
      accCnt <= accCnt + 1;
      if (regWe) begin
        case (regWidth)
          2'd0: mem[regAddr] <= regWdata[7:0];
          2'd1: begin
            mem[regAddr] <= regWdata[15:8]; mem[regAddr+10'd1] <= regWdata[7:0];
          end
          default: begin
            mem[regAddr]       <= regWdata[31:24];
            mem[regAddr+10'd1] <= regWdata[23:16];
            mem[regAddr+10'd2] <= regWdata[15:8];
            mem[regAddr+10'd3] <= regWdata[7:0];
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] sz, input logic [15:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output int nAcc, output int lat, output logic rdyLow);
    int c0;
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostSize = sz; hostAddr = addr; hostWdata = wd;
    c0 = accCnt;
    @(negedge clk);
    hostReq = 1'b0;
    rdyLow = !hostReady;
    lat = 1;
    while (!hostAck) begin @(negedge clk); lat++; end
    rd = hostRdata;
    nAcc = accCnt - c0;
  endtask

  task automatic doRead(input string tag, input logic [1:0] sz, input logic [15:0] addr,
                        input logic [31:0] exp, input int expAcc);
    logic [31:0] rd; int n, lat; logic rl;
    xfer(1'b0, sz, addr, 32'h0, rd, n, lat, rl);
    chk({tag, " data"}, rd, exp);
    chk({tag, " accesses"}, n, expAcc);
    chk({"R8 latency ", tag}, lat, (expAcc == 0) ? 1 : expAcc + 1);
  endtask

  task automatic doWrite(input string tag, input logic [1:0] sz, input logic [15:0] addr,
                         input logic [31:0] wd, input int expAcc);
    logic [31:0] rd; int n, lat; logic rl;
    xfer(1'b1, sz, addr, wd, rd, n, lat, rl);
    chk({tag, " accesses"}, n, expAcc);
    chk({"R8 latency ", tag}, lat, (expAcc == 0) ? 1 : expAcc + 1);
    if (expAcc != 0) chk({"R8 ready low ", tag}, rl, 1'b1);
  endtask

  task automatic testReset();
    chk("R1 hostReady", hostReady, 1'b1);
    chk("R1 hostAck", hostAck, 1'b0);
    chk("R1 regReq", regReq, 1'b0);
  endtask

  task automatic testMatched();
    doWrite("R3 word wr", 2'd2, 16'h0080, 32'h1122_3344, 1);
    doRead("R3 word rd", 2'd2, 16'h0080, 32'h1122_3344, 1);
    doWrite("R3 half wr", 2'd1, 16'h0040, 32'h0000_5566, 1);
    doRead("R3 half rd", 2'd1, 16'h0040, 32'h0000_5566, 1);
    doWrite("R3 byte wr", 2'd0, 16'h0010, 32'h0000_0077, 1);
    doRead("R3 byte rd", 2'd0, 16'h0010, 32'h0000_0077, 1);
  endtask

  task automatic testNarrowRead();
    doRead("R4 byte1 of word", 2'd0, 16'h0081, 32'h22, 1);
    doRead("R4 byte3 of word", 2'd0, 16'h0083, 32'h44, 1);
    doRead("R4 byte1 of half", 2'd0, 16'h0041, 32'h66, 1);
  endtask

  task automatic testRmw();
    doWrite("R5 byte into word", 2'd0, 16'h0082, 32'hAA, 2);
    doRead("R5 word after merge", 2'd2, 16'h0080, 32'h1122_AA44, 1);
    doWrite("R5 byte into half", 2'd0, 16'h0040, 32'h99, 2);
    doRead("R5 half after merge", 2'd1, 16'h0040, 32'h9966, 1);
  endtask

  task automatic testHalfOfWord();
    doRead("R6 low half", 2'd1, 16'h0082, 32'hAA44, 1);
    doRead("R6 high half", 2'd1, 16'h0080, 32'h1122, 1);
    doWrite("R6 high half wr", 2'd1, 16'h0080, 32'hBEEF, 2);
    doRead("R6 word after half wr", 2'd2, 16'h0080, 32'hBEEF_AA44, 1);
  endtask

  task automatic testSplit();
    doWrite("R7 word to bytes", 2'd2, 16'h0004, 32'hCAFE_F00D, 4);
    doRead("R7 first byte", 2'd0, 16'h0004, 32'hCA, 1);
    doRead("R7 last byte", 2'd0, 16'h0007, 32'h0D, 1);
    doRead("R7 half from bytes", 2'd1, 16'h0006, 32'hF00D, 2);
    doRead("R7 word from bytes", 2'd2, 16'h0004, 32'hCAFE_F00D, 4);
    doWrite("R7 word to halves", 2'd2, 16'h0048, 32'h0102_0304, 2);
    doRead("R7 second half", 2'd1, 16'h004A, 32'h0304, 1);
    doRead("R7 first half", 2'd1, 16'h0048, 32'h0102, 1);
    doWrite("R7 half to bytes", 2'd1, 16'h0020, 32'h1234, 2);
    doRead("R7 byte after half split", 2'd0, 16'h0021, 32'h34, 1);
  endtask

  task automatic testReject();
    doWrite("R2 write at 0x200", 2'd2, 16'h0200, 32'hFFFF_FFFF, 0);
    doRead("R2 read at 0x204", 2'd2, 16'h0204, 32'h0, 0);
    doRead("R2 masked high bits", 2'd2, 16'h0480, 32'hBEEF_AA44, 1);
    doRead("R2 masked to reject", 2'd0, 16'h0A10, 32'h0, 0);
  endtask

  task automatic testAlignDown();
    doRead("R10 half at odd", 2'd1, 16'h0083, 32'hAA44, 1);
    doRead("R10 word at 0x82", 2'd2, 16'h0082, 32'hBEEF_AA44, 1);
    doRead("R10 half on bytes odd", 2'd1, 16'h0005, 32'hCAFE, 2);
  endtask

  task automatic testWaitStates();
    int c0;
    ackOn = 1'b0;
    @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b1; hostSize = 2'd0; hostAddr = 16'h0083; hostWdata = 32'h5A;
    c0 = accCnt;
    @(negedge clk);
    hostReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 regReq held", regReq, 1'b1);
      chk("R9 addr stable", regAddr, 10'h080);
      chk("R9 read phase first", regWe, 1'b0);
      chk("R9 width word", regWidth, 2'd2);
      chk("R8 no early ack", hostAck, 1'b0);
      @(negedge clk);
    end
    ackOn = 1'b1;
    while (!hostAck) @(negedge clk);
    chk("R9 accesses after stall", accCnt - c0, 2);
    doRead("R9 merged word", 2'd2, 16'h0080, 32'hBEEF_AA5A, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMatched();
    testNarrowRead();
    testRmw();
    testHalfOfWord();
    testSplit();
    testReject();
    testAlignDown();
    testWaitStates();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule